// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the master side of a serial peripheral link. It takes parallel words from a valid/ready source, shifts each one out on a serial data line with the most significant bit first, and samples a word from the serial input line at the same time. Each received word comes back through a one-cycle valid strobe. The frame length can be set from 4 to 16 bits. Clock polarity and clock phase can be chosen. The serial clock comes from the system clock through a programmable half-period count.

The engine drives the serial clock, an active-low frame select and the transmit line itself. It opens a frame by pulling frame select low. When the clock phase is 1 it keeps frame select low across back-to-back words. When the clock phase is 0 it releases frame select between words, so that the slave can load its next word. In both phases frame select is released one full serial-clock period after the last bit is captured. Frame length, phase and half period are latched when a burst starts. Clock polarity is followed directly while the engine is idle.

Top module: `spim_master`

## Requirements
- R1: While idle, ss_n is 1, mosi is 0, sclk equals cpol, busy is 0 and tx_ready equals en.
- R2: A word offered while idle with en high is accepted at the edge where tx_valid and tx_ready are both high. ss_n is 0 and busy is 1 from that edge on.
- R3: The frame length is frame_len, limited to the range 4 to 16. The bits tx_data[len-1:0] are sent with bit len-1 first, and the higher bits are ignored.
- R4: A half period H is max(half_div,1) system cycles. The first sclk transition comes H cycles after ss_n falls, and transitions follow every H cycles after that.
- R5: With cpha=1, mosi changes on the leading (first) edge of each bit and mosi/miso are captured on the trailing edge. With cpha=0, the first bit is on mosi from the fall of ss_n, capture is on the leading edge, and mosi changes on the trailing edge.
- R6: cpol=1 makes the idle sclk level 1 and inverts every edge direction. The edge roles of R5 are unchanged.
- R7: The received word is shifted in MSB first and right-aligned in rx_data, with the bits above len at 0. rx_valid is high for exactly one cycle: the cycle after the edge that captures the last bit.
- R8: ss_n returns high 2H cycles after the last bit of the final word is captured.
- R9: With cpha=1, if a next word is valid at the last capture edge, it is accepted at that edge. ss_n stays low, and the new word's first leading edge follows H cycles later.
- R10: With cpha=0, ss_n rises after every word and stays high for at least 2H cycles before the next word's frame.
- R11: busy is high whenever ss_n is low. It stays high until the 2H-cycle gap after ss_n rises has passed.
- R12: With en low, tx_valid is ignored: tx_ready stays 0 and ss_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows new transfers to start |
| cpol | input | 1 | Clock polarity: idle level of sclk |
| cpha | input | 1 | Clock phase: 0 captures on leading edge, 1 on trailing edge |
| frame_len | input | 5 | Requested bits per word (limited to 4..16) |
| half_div | input | 8 | System cycles per sclk half period (0 is treated as 1) |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_valid | input | 1 | tx_data holds a word |
| tx_ready | output | 1 | Engine accepts tx_data this cycle |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| miso | input | 1 | Serial input from slave |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial output to slave |
| busy | output | 1 | Transfer or inter-frame gap in progress |

## Verification
The bench connects a behavioural slave that follows the edge rules of each mode. It covers all four polarity/phase combinations, the shortest and longest frames, a requested length outside the legal range, and a zero half-period count.

Each of these errors shows up as a data mismatch in one direction or the other:
- a swapped capture edge,
- a missing first bit in phase 0,
- a word left-aligned instead of right-aligned.

The bench also measures cycle distances from the frame-select fall to the first clock edge, and from the last capture to the release. A design that released frame select half a period early, or that toggled the clock at once, would miss those counts. Frame-select falls are counted per burst. A phase-1 design that pulsed select between words, or a phase-0 design that held it low, is caught this way.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } spim_state_e;

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] hp,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q >= hp - 1'b1);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4
    half_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hp > 1 && tick) |=> !tick);

endmodule

// File: rtl/spim_rx.sv
module spim_rx #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap,
    input  logic          last,
    input  logic          miso,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid
);

    typedef struct packed {
        logic [DW-1:0] sh;
        logic [DW-1:0] data;
        logic          valid;
    } rx_t;

    rx_t           r_d, r_q;
    logic [DW-1:0] shifted;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        shifted   = {r_q.sh[DW-2:0], miso};
        if (cap) begin
            r_d.sh = shifted;
        end
        if (last) begin
            r_d.data  = shifted;
            r_d.valid = 1'b1;
        end
        if (clr) begin
            r_d.sh = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data  = r_q.data;
    assign rx_valid = r_q.valid;

    // R7
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |=> !r_q.valid);

    // R7
    rx_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> $past(cap));

endmodule

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int DW      = 16,
    parameter int MIN_LEN = 4,
    parameter int DIV_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     cpol,
    input  logic                     cpha,
    input  logic [$clog2(DW+1)-1:0]  frame_len,
    input  logic [DIV_W-1:0]         half_div,
    input  logic [DW-1:0]            tx_data,
    input  logic                     tx_valid,
    output logic                     tx_ready,
    input  logic                     tick,
    output logic                     run,
    output logic [DIV_W-1:0]         hp,
    output logic                     cap,
    output logic                     last_cap,
    output logic                     word_take,
    output logic                     sclk,
    output logic                     ss_n,
    output logic                     mosi,
    output logic                     busy
);

    localparam int LEN_W = $clog2(DW+1);
    localparam int EW    = $clog2(2*DW+1);

    typedef struct packed {
        spim_state_e     st;
        logic            sclk;
        logic            ss_n;
        logic            mosi;
        logic            cpha;
        logic [DW-1:0]   tx_sh;
        logic [EW-1:0]   edg;
        logic            wait_n;
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] hp;
    } seq_t;

    seq_t             r_d, r_q;
    logic [LEN_W-1:0] len_in;
    logic [DIV_W-1:0] hp_in;
    logic [EW-1:0]    e_nx, two_len;
    logic             in_shift, lead, last_e, chg, cont, rdy, take;
    logic [DW-1:0]    al;

    function automatic logic [DW-1:0] align_f(logic [DW-1:0] d, logic [LEN_W-1:0] l);
        return d << (LEN_W'(DW) - l);
    endfunction

    always_comb begin
        r_d = r_q;

        if (frame_len < LEN_W'(MIN_LEN)) begin
            len_in = LEN_W'(MIN_LEN);
        end else if (frame_len > LEN_W'(DW)) begin
            len_in = LEN_W'(DW);
        end else begin
            len_in = frame_len;
        end
        hp_in = (half_div == '0) ? DIV_W'(1) : half_div;

        two_len  = EW'({r_q.len, 1'b0});
        e_nx     = r_q.edg + 1'b1;
        in_shift = (r_q.st == ST_SHIFT) && tick;
        lead     = e_nx[0];
        last_e   = (e_nx == two_len);
        cap      = in_shift && (r_q.cpha ? !lead : lead);
        last_cap = cap && (r_q.cpha ? last_e : (e_nx == two_len - 1'b1));
        chg      = in_shift && (r_q.cpha ? lead : (!lead && !last_e));
        cont     = in_shift && r_q.cpha && last_e && en;
        rdy      = ((r_q.st == ST_IDLE) && en) || cont;
        take     = rdy && tx_valid;
        al       = align_f(tx_data, (r_q.st == ST_IDLE) ? len_in : r_q.len);

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sclk = cpol;
                r_d.ss_n = 1'b1;
                r_d.mosi = 1'b0;
                if (take) begin
                    r_d.st    = ST_SHIFT;
                    r_d.ss_n  = 1'b0;
                    r_d.cpha  = cpha;
                    r_d.len   = len_in;
                    r_d.hp    = hp_in;
                    r_d.edg   = '0;
                    r_d.tx_sh = cpha ? al : (al << 1);
                    r_d.mosi  = cpha ? 1'b0 : al[DW-1];
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    r_d.sclk = ~r_q.sclk;
                    r_d.edg  = e_nx;
                    if (chg) begin
                        r_d.mosi  = r_q.tx_sh[DW-1];
                        r_d.tx_sh = r_q.tx_sh << 1;
                    end
                    if (last_e) begin
                        if (take) begin
                            r_d.edg   = '0;
                            r_d.tx_sh = al;
                        end else begin
                            r_d.st     = ST_TAIL;
                            r_d.wait_n = r_q.cpha;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (!r_q.wait_n) begin
                        r_d.ss_n   = 1'b1;
                        r_d.mosi   = 1'b0;
                        r_d.st     = ST_GAP;
                        r_d.wait_n = 1'b1;
                    end else begin
                        r_d.wait_n = 1'b0;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (!r_q.wait_n) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.wait_n = 1'b0;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ss_n <= 1'b1;
            r_q.len  <= LEN_W'(MIN_LEN);
            r_q.hp   <= DIV_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready  = rdy;
    assign word_take = take;
    assign run       = (r_q.st != ST_IDLE);
    assign hp        = r_q.hp;
    assign sclk      = r_q.sclk;
    assign ss_n      = r_q.ss_n;
    assign mosi      = r_q.mosi;
    assign busy      = (r_q.st != ST_IDLE);

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (r_q.ss_n && !r_q.mosi));

    // R2
    start_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!r_q.ss_n && busy));

    // R4
    first_edge_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ss_n) |-> $stable(r_q.sclk));

    // R9
    continuous_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cpha && last_cap && tx_valid && tx_ready) |=> !r_q.ss_n);

    // R11
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ss_n |-> busy);

endmodule

// File: rtl/spim_master.sv
module spim_master #(
    parameter int DW      = 16,
    parameter int MIN_LEN = 4,
    parameter int DIV_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    cpol,
    input  logic                    cpha,
    input  logic [$clog2(DW+1)-1:0] frame_len,
    input  logic [DIV_W-1:0]        half_div,
    input  logic [DW-1:0]           tx_data,
    input  logic                    tx_valid,
    output logic                    tx_ready,
    output logic [DW-1:0]           rx_data,
    output logic                    rx_valid,
    input  logic                    miso,
    output logic                    sclk,
    output logic                    ss_n,
    output logic                    mosi,
    output logic                    busy
);

    logic             tick, run, cap, last_cap, word_take;
    logic [DIV_W-1:0] hp;

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hp    (hp),
        .tick  (tick)
    );

    spim_seq #(.DW(DW), .MIN_LEN(MIN_LEN), .DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cpol      (cpol),
        .cpha      (cpha),
        .frame_len (frame_len),
        .half_div  (half_div),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tick      (tick),
        .run       (run),
        .hp        (hp),
        .cap       (cap),
        .last_cap  (last_cap),
        .word_take (word_take),
        .sclk      (sclk),
        .ss_n      (ss_n),
        .mosi      (mosi),
        .busy      (busy)
    );

    spim_rx #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (word_take),
        .cap      (cap),
        .last     (last_cap),
        .miso     (miso),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: tb/tb_spim_master.sv
module tb_spim_master;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [4:0]  frame_len = 5'd8;
    logic [7:0]  half_div = 8'd2;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        miso = 1'b0;
    logic        sclk, ss_n, mosi, busy;

    spim_master dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
        .frame_len(frame_len), .half_div(half_div), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .miso(miso), .sclk(sclk), .ss_n(ss_n),
        .mosi(mosi), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench view of the configuration
    int b_cpol = 0, b_cpha = 0, b_len = 8, b_hp = 2;
    int burst_id = 0;
    int nfalls = 0;

    logic [15:0] exp_tx[$];
    logic [15:0] exp_rx[$];
    logic [15:0] slv_q[$];
    logic [15:0] got_tx[$];

    int d_checks = 0, d_fails = 0, m_checks = 0, m_fails = 0;

    task automatic chk_d(input bit ok, input string req, input int act, input int exp);
        d_checks++;
        if (!ok) begin
            d_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural slave
    logic [15:0] s_out = '0, s_in = '0;
    int          s_cnt = 0;
    logic        prev_ss = 1'b1, prev_sclk = 1'b0;

    task automatic slave_load();
        s_out = (slv_q.size() > 0) ? slv_q.pop_front() : 16'h0;
        s_in  = '0;
        s_cnt = 0;
    endtask

    task automatic slave_edge();
        bit lead;
        lead = (sclk !== b_cpol[0]);
        if (lead == (b_cpha == 0)) begin
            s_in = {s_in[14:0], mosi};
            s_cnt++;
            if (s_cnt == b_len) begin
                got_tx.push_back(s_in);
                if (b_cpha == 1) slave_load();
            end
        end else if (s_cnt < b_len) begin
            miso = s_out[b_len-1-s_cnt];
        end
    endtask

    always @(ss_n or sclk) begin
        if (ss_n !== prev_ss) begin
            prev_ss = ss_n;
            if (ss_n === 1'b0) begin
                slave_load();
                if (b_cpha == 0) miso = s_out[b_len-1];
            end
        end
        if (sclk !== prev_sclk) begin
            prev_sclk = sclk;
            if (ss_n === 1'b0) slave_edge();
        end
    end

    // monitor: scoreboard and timing
    logic m_ss = 1'b1, m_sclk = 1'b0;
    int   t_fall = 0, t_rxv = 0, t_rise = -1, m_burst = 0;
    bit   pend = 1'b0;

    task automatic chk_m(input bit ok, input string req, input int act, input int exp);
        m_checks++;
        if (!ok) begin
            m_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (burst_id != m_burst) begin
                m_burst = burst_id;
                t_rise  = -1;
            end
            while (got_tx.size() > 0) begin
                logic [15:0] g, e;
                g = got_tx.pop_front();
                e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 16'hDEAD;
                // R3 R5 R6: slave saw the low len bits, MSB first
                chk_m(g == e, "R3/R5 mosi word", g, e);
            end
            if (rx_valid) begin
                logic [15:0] e;
                e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 16'hDEAD;
                // R7: right-aligned received word
                chk_m(rx_data == e, "R7 rx_data", rx_data, e);
                t_rxv = cyc;
            end
            if (m_ss === 1'b1 && ss_n === 1'b0) begin
                nfalls++;
                t_fall = cyc;
                pend   = 1'b1;
                // R11
                chk_m(busy === 1'b1, "R11 busy at select", busy, 1);
                // R10
                if (t_rise >= 0)
                    chk_m(cyc - t_rise >= 2*b_hp, "R10 gap", cyc - t_rise, 2*b_hp);
            end
            if (pend && sclk !== m_sclk) begin
                // R4
                chk_m(cyc - t_fall == b_hp, "R4 first edge", cyc - t_fall, b_hp);
                pend = 1'b0;
            end
            if (m_ss === 1'b0 && ss_n === 1'b1) begin
                // R8
                chk_m(cyc - t_rxv == 2*b_hp, "R8 release", cyc - t_rxv, 2*b_hp);
                // R11
                chk_m(busy === 1'b1, "R11 busy in gap", busy, 1);
                t_rise = cyc;
            end
            m_ss   = ss_n;
            m_sclk = sclk;
        end
    end

    task automatic run_burst(input int pol, input int pha, input int len_req,
                             input int hdiv, input int n, input logic [15:0] seed);
        logic [15:0] w[4];
        logic [15:0] mask;
        int          f0;
        b_cpol = pol;
        b_cpha = pha;
        b_len  = (len_req < 4) ? 4 : (len_req > 16) ? 16 : len_req;
        b_hp   = (hdiv == 0) ? 1 : hdiv;
        mask   = 16'hFFFF >> (16 - b_len);
        cpol      = pol[0];
        cpha      = pha[0];
        frame_len = 5'(len_req);
        half_div  = 8'(hdiv);
        en        = 1'b1;
        burst_id++;
        @(negedge clk);
        @(negedge clk);
        // R1 R6: idle levels
        chk_d(sclk == pol[0], "R6 idle sclk", sclk, pol);
        chk_d(ss_n && !mosi && !busy && tx_ready, "R1 idle lines",
              {ss_n, mosi, busy, tx_ready}, 4'b1001);
        f0 = nfalls;
        for (int i = 0; i < n; i++) begin
            logic [15:0] sw;
            w[i] = seed ^ (16'h9E37 * 16'(i + 1));
            sw   = ~seed ^ (16'h3C5A * 16'(i + 3));
            exp_tx.push_back(w[i] & mask);
            slv_q.push_back(sw);
            exp_rx.push_back(sw & mask);
        end
        for (int i = 0; i < n; i++) begin
            tx_data  = w[i];
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            if (i == 0) begin
                // R2
                chk_d(!ss_n && busy, "R2 start", {ss_n, busy}, 2'b01);
            end
        end
        tx_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R9 R10: number of frame-select falls in the burst
        chk_d(nfalls - f0 == ((pha == 1) ? 1 : n), (pha == 1) ? "R9 select held" : "R10 select pulsed",
              nfalls - f0, (pha == 1) ? 1 : n);
        chk_d(exp_tx.size() == 0 && exp_rx.size() == 0, "R7 all words seen",
              exp_tx.size() + exp_rx.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_d(ss_n && !sclk && !mosi && !busy && !rx_valid && !tx_ready, "R1 reset",
              {ss_n, sclk, mosi, busy, rx_valid, tx_ready}, 6'b100000);

        // R12: disabled engine ignores a valid word
        tx_data  = 16'h00F5;
        tx_valid = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk_d(!tx_ready && ss_n, "R12 disabled", {tx_ready, ss_n}, 2'b01);
        end
        tx_valid = 1'b0;

        run_burst(0, 1, 8,  2, 1, 16'h5A3C);
        run_burst(1, 1, 16, 3, 3, 16'hC0DE);
        run_burst(0, 0, 4,  1, 3, 16'h1234);
        run_burst(1, 0, 12, 4, 2, 16'hBEEF);
        run_burst(0, 0, 2,  0, 2, 16'h7E81);  // R3 clamp up, R4 zero divider
        run_burst(1, 1, 20, 2, 2, 16'hF00D);  // R3 clamp down
        run_burst(0, 1, 5,  5, 1, 16'h0F0F);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 d_checks + m_checks, d_fails + m_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 d_checks + m_checks + 1, d_fails + m_fails + 1);
        $finish;
    end

endmodule